// File: doc/BRIEF.md
# Delayed Modulator Trigger with Bi-Phase Control

This block times one modulator firing per sequence. A one-cycle sequence-start strobe begins each sequence. The block loads an 8-bit delay value and counts it down in ticks of one quarter of the clock rate. When the count runs out, the block raises the modulator trigger for a fixed width of about one microsecond. If the phase-flip option was on when the sequence started, a flip pulse of the same width follows at a fixed offset after the trigger rose.

The bi-phase control output is the exclusive-or of that flip pulse and a back-phase flag. A back-phase request that arrives between the start strobe and the trigger edge sets the flag. The flag then holds for the rest of that sequence and is cleared by the next start strobe. An indicator output shows the flag.

All pins are plain control levels or strobes. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. The flip offset must exceed the trigger width.

Top module: `modtrig_top`

## Requirements
- R1: While reset is held and right after it is released, `mod_trig`, `biphase_out` and `bphase_lit` are 0.
- R2: Let the start strobe be sampled at clock edge S and let D be the value of `delay_cfg` at that edge. `mod_trig` is first high after edge S+4·D+1. Changes of `delay_cfg` after edge S have no effect on that sequence.
- R3: `mod_trig` stays high for exactly 119 consecutive cycles and then returns to 0.
- R4: If `psk_enable` was 1 at edge S, a flip pulse is high for 119 cycles starting 1024 cycles after `mod_trig` rose, and it toggles `biphase_out` for that time. Later changes of `psk_enable` have no effect on that sequence.
- R5: If `psk_enable` was 0 at edge S, no flip pulse occurs in that sequence.
- R6: A `bphase_req` sampled at edge S, or at any edge from S+1 through S+4·D+1 (the edge on which the trigger rises), sets the back-phase flag from the next cycle. `bphase_lit` then shows 1 and `biphase_out` is inverted.
- R7: A `bphase_req` outside that window has no effect on `bphase_lit` or `biphase_out`. This covers a request after the trigger has risen and a request while the block is idle.
- R8: The next start strobe clears the back-phase flag, unless `bphase_req` is high in that same cycle.
- R9: A start strobe during a running sequence drops `mod_trig` and any flip pulse after that edge and starts a new delay count with the new delay value.
- R10: With a delay of 0, `mod_trig` rises after edge S+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (119 MHz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_start | input | 1 | Sequence-start strobe |
| delay_cfg | input | 8 | Trigger delay in quarter-rate ticks |
| psk_enable | input | 1 | Phase-flip enable, captured at start |
| bphase_req | input | 1 | Back-phase request for the current sequence |
| mod_trig | output | 1 | Modulator trigger pulse |
| biphase_out | output | 1 | Bi-phase modulator control (flip XOR back-phase) |
| bphase_lit | output | 1 | Back-phase flag indicator |

## Verification
The tests use delays of 0, small values and 255, together with a delay register and a flip enable that are inverted right after every start. These separate a count that is captured at start from one that follows the live value, and they show that the count runs at quarter rate. Back-phase requests are placed on the start edge, on the last edge of the window, one edge past it, and in idle time, which marks both ends of the acceptance window exactly. Restarts are issued while the delay is counting, while the trigger is high and while the flip pulse is high, so each abort path is covered. Runs with the flip enabled and disabled, with and without a latched back-phase flag, show both inputs of the XOR.

// File: rtl/modtrig_pkg.sv
package modtrig_pkg;
  localparam int DLY_W_DEF    = 8;
  localparam int PRESCALE_DEF = 4;
  localparam int TRIG_LEN_DEF = 119;
  localparam int FLIP_OFS_DEF = 1024;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TRIG = 2'd1,
    PH_GAP  = 2'd2,
    PH_FLIP = 2'd3
  } pulse_ph_e;
endpackage

// File: rtl/modtrig_delay.sv
module modtrig_delay #(
  parameter int DLY_W    = 8,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  output logic             fire,
  output logic             pending
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             busy;
  logic [DLY_W-1:0] rem;
  logic             tick;

  generate
    if (PRESCALE == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        pre <= '0;
        else if (start)                    pre <= '0;
        else if (busy) begin
          if (pre == PRE_W'(PRESCALE - 1)) pre <= '0;
          else                             pre <= pre + 1'b1;
        end
      end
      assign tick = (pre == PRE_W'(PRESCALE - 1));
    end
  endgenerate

  assign fire    = busy && (rem == '0);
  assign pending = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rem  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      rem  <= dly;
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      rem <= rem - 1'b1;
    end
  end

  a_r2_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !start) |=> !busy);
endmodule

// File: rtl/modtrig_pulse.sv
module modtrig_pulse
  import modtrig_pkg::*;
#(
  parameter int TRIG_LEN = 119,
  parameter int FLIP_OFS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fire,
  input  logic psk_en,
  output logic trig,
  output logic psk
);
  localparam int CNT_W = $clog2(FLIP_OFS + TRIG_LEN + 1);

  pulse_ph_e        ph;
  logic [CNT_W-1:0] tcnt;
  logic             psk_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      tcnt    <= '0;
      psk_cap <= 1'b0;
    end else if (start) begin
      ph      <= PH_IDLE;
      tcnt    <= '0;
      psk_cap <= psk_en;
    end else if (fire) begin
      ph   <= PH_TRIG;
      tcnt <= '0;
    end else begin
      case (ph)
        PH_TRIG: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == CNT_W'(TRIG_LEN - 1)) ph <= psk_cap ? PH_GAP : PH_IDLE;
        end
        PH_GAP: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == CNT_W'(FLIP_OFS - 1)) ph <= PH_FLIP;
        end
        PH_FLIP: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == CNT_W'(FLIP_OFS + TRIG_LEN - 1)) ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign trig = (ph == PH_TRIG);
  assign psk  = (ph == PH_FLIP);

  a_r3_trig_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_TRIG && tcnt < CNT_W'(TRIG_LEN - 1) && !start) |=> (ph == PH_TRIG));
  a_r5_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
    !psk_cap |-> (ph != PH_FLIP));
endmodule

// File: rtl/modtrig_phase.sv
module modtrig_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic req,
  input  logic window,
  input  logic psk,
  output logic bp,
  output logic biphase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               bp <= 1'b0;
    else if (start)           bp <= req;
    else if (req && window)   bp <= 1'b1;
  end

  assign biphase = psk ^ bp;

  a_r6_req_set: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (window || start)) |=> bp);
  a_r8_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !req) |=> !bp);
endmodule

// File: rtl/modtrig_top.sv
module modtrig_top
  import modtrig_pkg::*;
#(
  parameter int DLY_W    = DLY_W_DEF,
  parameter int PRESCALE = PRESCALE_DEF,
  parameter int TRIG_LEN = TRIG_LEN_DEF,
  parameter int FLIP_OFS = FLIP_OFS_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_start,
  input  logic [DLY_W-1:0] delay_cfg,
  input  logic             psk_enable,
  input  logic             bphase_req,
  output logic             mod_trig,
  output logic             biphase_out,
  output logic             bphase_lit
);
  logic fire, pending, psk_p, bp;

  modtrig_delay #(.DLY_W(DLY_W), .PRESCALE(PRESCALE)) u_dly (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .dly(delay_cfg),
    .fire(fire), .pending(pending)
  );

  modtrig_pulse #(.TRIG_LEN(TRIG_LEN), .FLIP_OFS(FLIP_OFS)) u_pls (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .fire(fire),
    .psk_en(psk_enable), .trig(mod_trig), .psk(psk_p)
  );

  modtrig_phase u_ph (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .req(bphase_req),
    .window(pending), .psk(psk_p), .bp(bp), .biphase(biphase_out)
  );

  assign bphase_lit = bp;

  a_r2_fire_to_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !seq_start) |=> mod_trig);
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (!mod_trig && !psk_p));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_trig && !seq_start) |=> $stable(bp));
  a_r4_flip_after: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psk_p) |-> !mod_trig);
endmodule

// File: tb/sim_modtrig_top.sv
`timescale 1ns/1ps
module sim_modtrig_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seq_start = 1'b0;
  logic [7:0] delay_cfg = 8'd0;
  logic       psk_enable = 1'b0;
  logic       bphase_req = 1'b0;
  logic       mod_trig, biphase_out, bphase_lit;

  always #4 clk = ~clk;

  modtrig_top u0 (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .delay_cfg(delay_cfg),
    .psk_enable(psk_enable), .bphase_req(bphase_req),
    .mod_trig(mod_trig), .biphase_out(biphase_out), .bphase_lit(bphase_lit)
  );

  typedef struct {
    int         cyc;
    logic [2:0] v;
    string      tag;
  } ev_t;

  ev_t        evq[$];
  ev_t        ev;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_fail = 0;
  logic [2:0] last_exp = 3'b000;
  logic [2:0] last_obs = 3'b000;
  logic [2:0] cur;
  bit         mon_en = 1'b0;
  bit         done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: every observed change of {mod_trig, biphase_out, bphase_lit}
  always @(negedge clk) begin
    if (mon_en && !done) begin
      cur = {mod_trig, biphase_out, bphase_lit};
      if (cur !== last_obs) begin
        if (evq.size() == 0) begin
          chk(1'b0, "R2 R7 unexpected change", int'(cur), int'(last_obs));
        end else begin
          ev = evq.pop_front();
          chk(ev.cyc == cyc && ev.v === cur, ev.tag, cyc * 8 + int'(cur), ev.cyc * 8 + int'(ev.v));
        end
        last_obs = cur;
      end
    end
  end

  // driver: predict the whole sequence, then drive it
  task automatic run_seq(input int d, input bit p, input int bpk, input int run, input string tag);
    int cs;
    @(negedge clk);
    cs = cyc + 1;
    for (int k = 0; k < run; k++) begin
      bit tr, ps, bp;
      int tk;
      logic [2:0] v;
      tr = (k >= 4 * d + 1) && (k <= 4 * d + 119);
      tk = k - (4 * d + 1);
      ps = p && (tk >= 1024) && (tk <= 1142);
      bp = (bpk >= 0) && (bpk <= 4 * d + 1) && (k >= bpk);
      v  = {tr, ps ^ bp, bp};
      if (v !== last_exp) begin
        evq.push_back('{cs + k, v, tag});
        last_exp = v;
      end
    end
    for (int k = 0; k < run; k++) begin
      if (k > 0) @(negedge clk);
      seq_start  = (k == 0);
      bphase_req = (k == bpk);
      delay_cfg  = (k == 0) ? d[7:0] : ~d[7:0];
      psk_enable = (k == 0) ? p : !p;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      seq_start  = 1'b0;
      bphase_req = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mod_trig == 1'b0, "R1 trig in reset", int'(mod_trig), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mod_trig == 1'b0, "R1 trig after reset", int'(mod_trig), 0);
    chk(biphase_out == 1'b0, "R1 biphase after reset", int'(biphase_out), 0);
    chk(bphase_lit == 1'b0, "R1 indicator after reset", int'(bphase_lit), 0);
    mon_en = 1'b1;

    run_seq(3,   1'b1, -1,   1200, "R2 R3 R4 basic flip");
    run_seq(0,   1'b0, 0,    200,  "R10 R5 R6 zero delay, request on start");
    run_seq(10,  1'b1, 41,   1250, "R6 R4 R8 request on last window edge");
    run_seq(5,   1'b0, 22,   200,  "R7 R8 request one edge late");
    run_seq(200, 1'b1, 5,    300,  "R9 R6 restart during delay");
    run_seq(2,   1'b1, -1,   30,   "R9 restart during trigger");
    run_seq(1,   1'b1, -1,   1050, "R9 R4 restart during flip");
    run_seq(255, 1'b0, 2000, 2100, "R2 R7 max delay, idle request");
    run_seq(0,   1'b1, -1,   1200, "R10 R4 zero delay with flip");
    idle(20);

    chk(evq.size() == 0, "R3 R4 pending expected edges", evq.size(), 0);
    chk(mod_trig == 1'b0, "R3 trig idle at end", int'(mod_trig), 0);
    chk(biphase_out == 1'b0, "R5 biphase idle at end", int'(biphase_out), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R2 watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule